// File: doc/BRIEF.md
# Iterative Double-Width Integer Divider

This block divides a 64-bit dividend by a 32-bit divisor and returns a 32-bit quotient and a 32-bit remainder. The dividend is assembled from two 32-bit input words. A mode input selects unsigned or two's complement signed operation. The caller asserts `start` for one cycle with the operands valid. The block then works alone and pulses `done`.

At the `done` pulse the block either updates its result words or raises `fault`. A fault means the divisor was zero, or the true quotient cannot be held in a 32-bit result of the selected mode. The engine strips signs first and then runs a restoring shift-subtract loop on magnitudes, one quotient bit per clock. It restores signs on the way out. No arithmetic flags are produced.

Top module: `wide_divider`

## Requirements
- R1: The dividend is `{dvd_hi, dvd_lo}`: `dvd_hi` is bits 63:32 and `dvd_lo` is bits 31:0.
- R2: A zero divisor in either mode gives `done` with `fault`=1 on the second clock edge after the edge that samples `start`.
- R3: In unsigned mode (`is_signed`=0), a quotient of 2^32 or more raises `fault`. A quotient of at most 2^32-1 does not.
- R4: In signed mode (`is_signed`=1), a quotient outside -2^31 to 2^31-1 raises `fault`. Both ends of that range are accepted.
- R5: In unsigned mode without fault, `quo` is the floor of dividend/divisor and `rem` is dividend minus quo*divisor.
- R6: In signed mode without fault, the quotient is truncated toward zero. The remainder has the sign of the dividend (or is zero), and its magnitude is below the divisor's magnitude.
- R7: On a fault, `quo` and `rem` keep the values from the last successful division (zero after reset).
- R8: `done` is high for exactly one cycle per accepted operation. `fault` is high only in a cycle where `done` is high.
- R9: A `start` seen while an operation is in progress is ignored. It produces no extra `done` and does not disturb the running result.
- R10: With a non-zero divisor, `done` rises on the 66th clock edge counting from the edge that samples `start` (1 load + 64 iterations + 1 output edge).
- R11: After reset, `done`=0, `fault`=0, `quo`=0 and `rem`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dvd_hi | input | 32 | Upper word of the dividend |
| dvd_lo | input | 32 | Lower word of the dividend |
| dvsr | input | 32 | Divisor |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault, valid with `done` |
| quo | output | 32 | Quotient of the last successful division |
| rem | output | 32 | Remainder of the last successful division |

## Verification
The assertions assume that the operands are stable on the cycle where `start` is sampled. They also assume that `start` arrives only as a pulse while idle, except when busy-time starts are being tested on purpose. The check that the running partial remainder stays below the divisor relies on the engine never iterating with a zero divisor. The control path guarantees that, so the stimulus can freely include zero divisors. The driver applies every operand change and `start` pulse on the falling clock edge. It holds each operation's inputs until its `done`, and changes inputs mid-run only in the deliberate busy-start case.

// File: rtl/wdiv_pkg.sv
// Shared types for the double-width divider.
// Assumes nothing beyond a single clock domain.
package wdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } wdiv_state_e;
endpackage

// File: rtl/wdiv_prep.sv
// Operand preparation: builds the double-width dividend, takes magnitudes
// in signed mode and derives result signs and the zero-divisor flag.
// Purely combinational; assumes inputs are valid whenever it is sampled.
module wdiv_prep #(
    parameter int W = 32
) (
    input  logic           is_signed,
    input  logic [W-1:0]   hi_word,
    input  logic [W-1:0]   lo_word,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dvs_mag,
    output logic           neg_quo,
    output logic           neg_rem,
    output logic           dvs_zero
);
    logic [2*W-1:0] dvd_full;
    logic           dvd_neg;
    logic           dvs_neg;

    // Form magnitudes and sign information from the raw operands.
    always_comb begin
        dvd_full = {hi_word, lo_word};
        dvd_neg  = is_signed & hi_word[W-1];
        dvs_neg  = is_signed & divisor[W-1];
        dvd_mag  = dvd_neg ? (~dvd_full + 1'b1) : dvd_full;
        dvs_mag  = dvs_neg ? (~divisor + 1'b1) : divisor;
        neg_quo  = dvd_neg ^ dvs_neg;
        neg_rem  = dvd_neg;
        dvs_zero = (divisor == '0);
    end
endmodule

// File: rtl/wdiv_core.sv
// Restoring shift-subtract engine on unsigned magnitudes.
// One quotient bit per step; after 2*W steps qbits holds the quotient and
// part holds the remainder. Assumes the divisor magnitude is non-zero
// whenever step is asserted.
module wdiv_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dvs_mag,
    output logic [2*W-1:0] quo_mag,
    output logic [W-1:0]   rem_mag
);
    logic [W-1:0]   part;
    logic [2*W-1:0] qbits;
    logic [W-1:0]   dreg;
    logic [W:0]     shifted;
    logic [W:0]     diff;
    logic           take;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {part, qbits[2*W-1]};
        diff    = shifted - {1'b0, dreg};
        take    = (shifted >= {1'b0, dreg});
    end

    // Load operands or advance one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part  <= '0;
            qbits <= '0;
            dreg  <= '0;
        end else if (load) begin
            part  <= '0;
            qbits <= dvd_mag;
            dreg  <= dvs_mag;
        end else if (step) begin
            part  <= take ? diff[W-1:0] : shifted[W-1:0];
            qbits <= {qbits[2*W-2:0], take};
        end
    end

    assign quo_mag = qbits;
    assign rem_mag = part;

    // The partial remainder never reaches the divisor while iterating.
    assert_partial_below_divisor_R6: assert property (
        @(posedge clk) disable iff (!rst_n) step |-> (part < dreg));
endmodule

// File: rtl/wdiv_post.sv
// Result finishing: range check of the magnitude quotient for the chosen
// mode and sign restoration of quotient and remainder.
// Purely combinational; assumes magnitudes come from a completed run.
module wdiv_post #(
    parameter int W = 32
) (
    input  logic           is_signed,
    input  logic           neg_quo,
    input  logic           neg_rem,
    input  logic [2*W-1:0] quo_mag,
    input  logic [W-1:0]   rem_mag,
    output logic [W-1:0]   quo_out,
    output logic [W-1:0]   rem_out,
    output logic           too_big
);
    logic upper_set;
    logic lower_tail;

    // Decide whether the quotient fits and apply the result signs.
    always_comb begin
        upper_set  = |quo_mag[2*W-1:W];
        lower_tail = |quo_mag[W-2:0];
        if (!is_signed)
            too_big = upper_set;
        else if (neg_quo)
            too_big = upper_set | (quo_mag[W-1] & lower_tail);
        else
            too_big = upper_set | quo_mag[W-1];
        quo_out = neg_quo ? (~quo_mag[W-1:0] + 1'b1) : quo_mag[W-1:0];
        rem_out = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/wide_divider.sv
// Top of the double-width divider: start/done control, operand capture and
// result registers. Accepts start only when idle, reports a zero divisor
// after one cycle and otherwise after 2*W iterations plus one output cycle.
// Assumes operands are valid in the cycle start is sampled.
module wide_divider
    import wdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvsr,
    output logic         done,
    output logic         fault,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(2 * W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(2 * W - 1);

    wdiv_state_e    state;
    logic [CNT_W-1:0] cnt;
    logic           mode_r;
    logic           negq_r;
    logic           negr_r;
    logic           zero_r;

    logic [2*W-1:0] dvd_mag;
    logic [W-1:0]   dvs_mag;
    logic           neg_quo;
    logic           neg_rem;
    logic           dvs_zero;
    logic [2*W-1:0] quo_mag;
    logic [W-1:0]   rem_mag;
    logic [W-1:0]   quo_fin;
    logic [W-1:0]   rem_fin;
    logic           too_big;
    logic           accept;

    assign accept = (state == ST_IDLE) && start;

    wdiv_prep #(.W(W)) u_prep (
        .is_signed (is_signed),
        .hi_word   (dvd_hi),
        .lo_word   (dvd_lo),
        .divisor   (dvsr),
        .dvd_mag   (dvd_mag),
        .dvs_mag   (dvs_mag),
        .neg_quo   (neg_quo),
        .neg_rem   (neg_rem),
        .dvs_zero  (dvs_zero)
    );

    wdiv_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state == ST_RUN),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    wdiv_post #(.W(W)) u_post (
        .is_signed (mode_r),
        .neg_quo   (negq_r),
        .neg_rem   (negr_r),
        .quo_mag   (quo_mag),
        .rem_mag   (rem_mag),
        .quo_out   (quo_fin),
        .rem_out   (rem_fin),
        .too_big   (too_big)
    );

    // Sequence the operation and capture mode and sign information.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_r <= 1'b0;
            negq_r <= 1'b0;
            negr_r <= 1'b0;
            zero_r <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    mode_r <= is_signed;
                    negq_r <= neg_quo;
                    negr_r <= neg_rem;
                    zero_r <= dvs_zero;
                    cnt    <= '0;
                    state  <= dvs_zero ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_STEP) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the completion pulse and update results only when no fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            fault <= 1'b0;
            quo   <= '0;
            rem   <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            if (state == ST_FIN) begin
                done <= 1'b1;
                if (zero_r || too_big) begin
                    fault <= 1'b1;
                end else begin
                    quo <= quo_fin;
                    rem <= rem_fin;
                end
            end
        end
    end

    assert_zero_divisor_fault_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (accept && dvsr == '0) |=> ##1 (done && fault));

    assert_hold_on_fault_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(quo) && $stable(rem)));

    assert_done_single_R8: assert property (
        @(posedge clk) disable iff (!rst_n) done |=> !done);

    assert_fault_with_done_R8: assert property (
        @(posedge clk) disable iff (!rst_n) fault |-> done);

    assert_run_continues_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN || state == ST_FIN));

    assert_quiet_while_running_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (state == ST_RUN) |-> !done);
endmodule

// File: tb/wide_divider_test.sv
// Scoreboard bench: the driver predicts each result into queues, the
// monitor pops and compares on every done pulse.
module wide_divider_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dvd_hi = '0;
    logic [31:0] dvd_lo = '0;
    logic [31:0] dvsr = '0;
    logic        done;
    logic        fault;
    logic [31:0] quo;
    logic [31:0] rem;

    int errors = 0;
    int checks = 0;
    logic [31:0] last_q = '0;
    logic [31:0] last_r = '0;
    logic [31:0] seed = 32'h1234_5677;

    logic        exp_f[$];
    logic [31:0] exp_q[$];
    logic [31:0] exp_r[$];
    string       exp_tag[$];

    always #(PERIOD / 2) clk = ~clk;

    wide_divider uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
        .done(done), .fault(fault), .quo(quo), .rem(rem)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lcg();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Monitor: compare every done pulse against the oldest prediction.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault && !done)
                chk(1'b0, "R8", "fault without done", 64'(fault), 64'd0);
            if (done) begin
                if (exp_f.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 64'(done), 64'd0);
                end else begin
                    automatic logic        ef = exp_f.pop_front();
                    automatic logic [31:0] eq = exp_q.pop_front();
                    automatic logic [31:0] er = exp_r.pop_front();
                    automatic string       et = exp_tag.pop_front();
                    chk(fault == ef, et, "fault", 64'(fault), 64'(ef));
                    chk(quo == eq, et, "quotient", 64'(quo), 64'(eq));
                    chk(rem == er, et, "remainder", 64'(rem), 64'(er));
                end
            end
        end
    end

    // Driver: predict, issue one operation and time its completion.
    task automatic issue(input logic sg, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] d,
                         input string tag, input bit poke);
        logic [63:0] dv, mdv, qm, rm;
        logic [31:0] md, q, r;
        logic        sd, sv, f;
        int          n;
        int          want;
        dv  = {hi, lo};
        sd  = sg & hi[31];
        sv  = sg & d[31];
        mdv = sd ? -dv : dv;
        md  = sv ? -d : d;
        if (d == 0) begin
            f = 1'b1; q = last_q; r = last_r;
        end else begin
            qm = mdv / {32'h0, md};
            rm = mdv % {32'h0, md};
            if (!sg) f = (qm > 64'hFFFF_FFFF);
            else if (sd ^ sv) f = (qm > 64'h8000_0000);
            else f = (qm > 64'h7FFF_FFFF);
            if (f) begin
                q = last_q; r = last_r;
            end else begin
                q = (sd ^ sv) ? -qm[31:0] : qm[31:0];
                r = sd ? -rm[31:0] : rm[31:0];
                last_q = q; last_r = r;
            end
        end
        exp_f.push_back(f); exp_q.push_back(q);
        exp_r.push_back(r); exp_tag.push_back(tag);
        @(negedge clk);
        is_signed = sg; dvd_hi = hi; dvd_lo = lo; dvsr = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            if (poke && n == 10) begin
                start = 1'b1; dvd_lo = ~lo; dvsr = d ^ 32'h3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        want = (d == 0) ? 1 : 65;
        chk(n == want, (d == 0) ? "R2" : "R10", "latency", 64'(n), 64'(want));
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", 64'(done), 64'd0);
    endtask

    initial begin
        #(PERIOD * 200000);
        chk(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(done == 0 && fault == 0, "R11", "reset flags", {done, fault}, 64'd0);
        chk(quo == 0 && rem == 0, "R11", "reset results", {quo, rem}, 64'd0);

        issue(1'b0, 32'h0, 32'd100, 32'd7, "R5", 1'b0);
        issue(1'b0, 32'h1, 32'h0, 32'd2, "R1", 1'b0);
        issue(1'b0, 32'h5, 32'h3, 32'h10, "R1", 1'b0);
        issue(1'b0, 32'h0, 32'd55, 32'd0, "R2", 1'b0);       // held: R7
        issue(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd0, "R2", 1'b0);
        issue(1'b0, 32'h2, 32'h0, 32'd2, "R3", 1'b0);        // 2^32 -> fault
        issue(1'b0, 32'h1, 32'hFFFF_FFFF, 32'd2, "R3", 1'b0); // 2^32-1 fits
        issue(1'b0, 32'h8, 32'h0, 32'h3, "R7", 1'b0);        // fault, hold
        issue(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, "R6", 1'b0);
        issue(1'b1, 32'h0, 32'd7, 32'hFFFF_FFFE, "R6", 1'b0);
        issue(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6", 1'b0);
        issue(1'b1, 32'h0, 32'h8000_0000, 32'd1, "R4", 1'b0); // +2^31 fault
        issue(1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, "R4", 1'b0); // -2^31 ok
        issue(1'b1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, "R4", 1'b0);
        issue(1'b1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, "R4", 1'b0);
        issue(1'b1, 32'h0, 32'h7FFF_FFFF, 32'd1, "R4", 1'b0); // max positive
        issue(1'b0, 32'h0, 32'd1000, 32'd9, "R9", 1'b1);      // busy start
        for (int i = 0; i < 24; i++) begin
            automatic logic [31:0] h = lcg() >> (lcg() & 32'd31);
            automatic logic [31:0] l = lcg();
            automatic logic [31:0] d = lcg() | 32'h1;
            issue(i[0], h, l, d, i[0] ? "R6" : "R5", 1'b0);
        end
        repeat (80) @(negedge clk);
        chk(exp_f.size() == 0, "R9", "pending predictions", 64'(exp_f.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule